// File: doc/BRIEF.md
# Shared Bus Admission Arbiter with Ordered Retry

This block decides, cycle by cycle, which of several requester ports may place a packet on one shared bus. A normal packet wins only if the bus is idle and no earlier refused requester is waiting ahead of it. Each winning transfer keeps the bus occupied for a number of bus cycles set by its length. The bus moves 16 bytes per cycle, so the occupancy is the byte count divided by 16, rounded up.

A refused port joins the tail of an ordered waiting list. When the bus next goes idle, the block opens a retry window and sends a one-cycle retry strobe to the port at the head of the list. During that window only the head port can be admitted. Snoop packets flagged as express are always admitted. They ignore occupancy and the waiting list, and they change neither.

The accept and refuse outputs are combinational on the current request. The occupancy, the list and the window are updated at the clock edge.

Top module: `bus_admit_arbiter`

## Requirements
- R1: A valid packet with its express flag set is accepted in the same cycle, whatever the busy state, the list contents or the window state. It does not change occupancy, the list or the window.
- R2: An accepted normal packet of B bytes occupies the bus for max(1, ceil(B/16)) cycles after its accept cycle. During those cycles every normal request is refused.
- R3: A refused normal request sees refuse high and accept low in its request cycle. The port is then appended to the tail of the waiting list.
- R4: While the list is non-empty, a normal request is accepted only if the window is open and the request comes from the head port.
- R5: If the bus is idle, the list is non-empty and the window is closed in a cycle, the window opens in the next cycle. In that next cycle retry pulses high for exactly one cycle, on the head port's bit only.
- R6: Accepting the head during an open window removes it from the list and closes the window. The following head gets its retry only after the bus has been idle for one cycle again.
- R7: A port that is already on the list is never appended again, so the list never holds more entries than there are ports.
- R8: When several normal requests are eligible in one cycle, the lowest port index wins. Refused ports that are not yet listed are appended in ascending index order.
- R9: After reset the list is empty, the bus is idle, the window is closed and retry is all zero. A first normal request is then accepted at once.
- R10: At most one normal packet is accepted per cycle, and no port sees accept and refuse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Per-port packet present |
| req_express | input | NUM_PORTS | Per-port express snoop flag |
| req_bytes | input | NUM_PORTS*LEN_W | Per-port packet length in bytes, port p at bits [p*LEN_W +: LEN_W] |
| accept | output | NUM_PORTS | Packet admitted this cycle |
| refuse | output | NUM_PORTS | Normal packet turned away this cycle |
| retry | output | NUM_PORTS | One-cycle invitation to the list head |

## Verification
Two functions can fall in the same cycle. An express snoop can arrive in the cycle where the head port takes its retry window, and a new normal refusal can be appended while the head is popped. The random stimulus makes ports re-request as soon as they see retry, and it mixes express flags and fresh requests into those same cycles. A bench model of occupancy, list and window then predicts accept, refuse and retry for every port. A directed opening sequence also times the retry gaps, and checks that a port refused twice is invited only once.

// File: rtl/bus_admit_pkg.sv
package bus_admit_pkg;

    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_e;

    // Bus cycles a packet holds the bus: at least one, else ceil(bytes / width).
    function automatic int unsigned occ_cycles(input int unsigned nbytes,
                                               input int unsigned bus_bytes);
        if (nbytes == 0) return 1;
        return (nbytes + bus_bytes - 1) / bus_bytes;
    endfunction

endpackage

// File: rtl/bus_occupancy_timer.sv
module bus_occupancy_timer
    import bus_admit_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int BUS_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] nbytes,
    output logic             busy
);
    localparam int MAX_OCC = ((1 << LEN_W) - 1 + BUS_BYTES - 1) / BUS_BYTES;
    localparam int CNT_W   = $clog2(MAX_OCC + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start) begin
            remain <= CNT_W'(occ_cycles(int'(nbytes), BUS_BYTES));
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/retry_order_list.sv
module retry_order_list #(
    parameter int NUM_PORTS = 4,
    parameter int IDX_W     = 2,
    parameter int CNT_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pop,
    input  logic [NUM_PORTS-1:0] push,
    output logic [IDX_W-1:0]     head,
    output logic                 empty,
    output logic [NUM_PORTS-1:0] member,
    output logic [CNT_W-1:0]     count
);
    logic [IDX_W-1:0] slots     [NUM_PORTS];
    logic [IDX_W-1:0] slots_nxt [NUM_PORTS];
    logic [CNT_W-1:0] count_nxt;
    int               fill;

    always_comb begin
        for (int s = 0; s < NUM_PORTS; s++) slots_nxt[s] = slots[s];
        fill = int'(count);
        if (pop && count != '0) begin
            for (int s = 0; s < NUM_PORTS - 1; s++) slots_nxt[s] = slots[s + 1];
            slots_nxt[NUM_PORTS-1] = '0;
            fill = fill - 1;
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (push[p] && fill < NUM_PORTS) begin
                for (int s = 0; s < NUM_PORTS; s++) begin
                    if (s == fill) slots_nxt[s] = IDX_W'(p);
                end
                fill = fill + 1;
            end
        end
        count_nxt = CNT_W'(fill);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_PORTS; s++) slots[s] <= '0;
            count <= '0;
        end else begin
            for (int s = 0; s < NUM_PORTS; s++) slots[s] <= slots_nxt[s];
            count <= count_nxt;
        end
    end

    always_comb begin
        member = '0;
        for (int s = 0; s < NUM_PORTS; s++) begin
            if (CNT_W'(s) < count) member[slots[s]] = 1'b1;
        end
    end

    assign head  = slots[0];
    assign empty = (count == '0);
endmodule

// File: rtl/admit_grant_logic.sv
module admit_grant_logic #(
    parameter int NUM_PORTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_PORTS-1:0] req_valid,
    input  logic [NUM_PORTS-1:0] req_express,
    input  logic                 busy,
    input  logic                 list_empty,
    input  logic                 win_open,
    input  logic [IDX_W-1:0]     head,
    input  logic [NUM_PORTS-1:0] member,
    output logic [NUM_PORTS-1:0] accept,
    output logic [NUM_PORTS-1:0] refuse,
    output logic [NUM_PORTS-1:0] push,
    output logic                 grant,
    output logic [IDX_W-1:0]     grant_idx,
    output logic                 pop
);
    logic [NUM_PORTS-1:0] normal;
    logic [NUM_PORTS-1:0] eligible;
    logic [NUM_PORTS-1:0] win_oh;

    assign normal = req_valid & ~req_express;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_elig
            assign eligible[p] = normal[p] && !busy &&
                                 (list_empty || (win_open && head == IDX_W'(p)));
        end
    endgenerate

    always_comb begin
        win_oh    = '0;
        grant_idx = '0;
        grant     = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (eligible[p] && !grant) begin
                win_oh[p] = 1'b1;
                grant_idx = IDX_W'(p);
                grant     = 1'b1;
            end
        end
    end

    assign accept = (req_valid & req_express) | win_oh;
    assign refuse = normal & ~win_oh;
    assign push   = refuse & ~member;
    assign pop    = grant & win_open;
endmodule

// File: rtl/bus_admit_arbiter.sv
module bus_admit_arbiter
    import bus_admit_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int LEN_W     = 8,
    parameter int BUS_BYTES = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PORTS-1:0]       req_valid,
    input  logic [NUM_PORTS-1:0]       req_express,
    input  logic [NUM_PORTS*LEN_W-1:0] req_bytes,
    output logic [NUM_PORTS-1:0]       accept,
    output logic [NUM_PORTS-1:0]       refuse,
    output logic [NUM_PORTS-1:0]       retry
);
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int CNT_W = $clog2(NUM_PORTS + 1);

    logic                 busy;
    logic                 list_empty;
    logic [IDX_W-1:0]     head;
    logic [NUM_PORTS-1:0] member;
    logic [CNT_W-1:0]     list_count;
    logic [NUM_PORTS-1:0] push;
    logic                 pop;
    logic                 grant;
    logic [IDX_W-1:0]     grant_idx;
    logic [LEN_W-1:0]     grant_bytes;
    win_state_e           win_q;
    logic                 win_open;
    logic                 open_now;
    logic [NUM_PORTS-1:0] head_oh;
    logic [NUM_PORTS-1:0] retry_q;

    assign win_open    = (win_q == WIN_OPEN);
    assign grant_bytes = req_bytes[grant_idx*LEN_W +: LEN_W];
    assign open_now    = !busy && !list_empty && !win_open;

    always_comb begin
        head_oh       = '0;
        head_oh[head] = 1'b1;
    end

    admit_grant_logic #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_grant (
        .req_valid  (req_valid),
        .req_express(req_express),
        .busy       (busy),
        .list_empty (list_empty),
        .win_open   (win_open),
        .head       (head),
        .member     (member),
        .accept     (accept),
        .refuse     (refuse),
        .push       (push),
        .grant      (grant),
        .grant_idx  (grant_idx),
        .pop        (pop)
    );

    retry_order_list #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_list (
        .clk   (clk),
        .rst   (rst),
        .pop   (pop),
        .push  (push),
        .head  (head),
        .empty (list_empty),
        .member(member),
        .count (list_count)
    );

    bus_occupancy_timer #(.LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (grant),
        .nbytes(grant_bytes),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q   <= WIN_CLOSED;
            retry_q <= '0;
        end else begin
            retry_q <= '0;
            if (open_now) begin
                win_q   <= WIN_OPEN;
                retry_q <= head_oh;
            end else if (pop) begin
                win_q <= WIN_CLOSED;
            end
        end
    end

    assign retry = retry_q;
endmodule

// File: rtl/bus_admit_arbiter_chk.sv
module bus_admit_arbiter_chk #(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_PORTS-1:0] req_valid,
    input logic [NUM_PORTS-1:0] req_express,
    input logic [NUM_PORTS-1:0] accept,
    input logic [NUM_PORTS-1:0] refuse,
    input logic [NUM_PORTS-1:0] retry,
    input logic                 busy,
    input logic                 win_open,
    input logic                 list_empty,
    input logic [CNT_W-1:0]     list_count
);
    logic [NUM_PORTS-1:0] expr_v;
    logic [NUM_PORTS-1:0] norm_acc;
    assign expr_v   = req_valid & req_express;
    assign norm_acc = accept & ~expr_v;

    p_express_taken_r1: assert property (@(posedge clk) disable iff (rst)
        (expr_v & ~accept) == '0);
    p_busy_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (norm_acc == '0));
    p_grant_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (norm_acc != '0) |=> busy);
    p_head_only_r4: assert property (@(posedge clk) disable iff (rst)
        (!list_empty && !win_open) |-> (norm_acc == '0));
    p_retry_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(retry));
    p_retry_in_window_r5: assert property (@(posedge clk) disable iff (rst)
        (retry != '0) |-> win_open);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        list_count <= CNT_W'(NUM_PORTS));
    p_single_normal_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(norm_acc) <= 1);
    p_acc_ref_excl_r10: assert property (@(posedge clk) disable iff (rst)
        (accept & refuse) == '0);
endmodule

bind bus_admit_arbiter bus_admit_arbiter_chk #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_express(req_express),
    .accept     (accept),
    .refuse     (refuse),
    .retry      (retry),
    .busy       (busy),
    .win_open   (win_open),
    .list_empty (list_empty),
    .list_count (list_count)
);

// File: tb/bus_admit_arbiter_bench.sv
`timescale 1ns/1ps
module bus_admit_arbiter_bench;
    localparam int N  = 4;
    localparam int LW = 8;
    localparam int BB = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req_valid = '0;
    logic [N-1:0]  req_express = '0;
    logic [N*LW-1:0] req_bytes = '0;
    logic [N-1:0]  accept, refuse, retry;

    always #10 clk = ~clk;

    bus_admit_arbiter #(.NUM_PORTS(N), .LEN_W(LW), .BUS_BYTES(BB)) u_bus_admit_arbiter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_express(req_express),
        .req_bytes(req_bytes), .accept(accept), .refuse(refuse), .retry(retry)
    );

    int          checks = 0;
    int          fails  = 0;
    int          m_busy = 0;
    int          m_q[$];
    bit          m_win  = 0;
    bit          m_popped = 0;
    logic [N-1:0] m_retry = '0;
    int          cyc = 0;
    int          retry_seen[N];
    int          retry_cyc[N];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int occ(input int b);
        if (b == 0) return 1;
        return (b + BB - 1) / BB;
    endfunction

    function automatic bit in_list(input int p);
        foreach (m_q[i]) if (m_q[i] == p) return 1;
        return 0;
    endfunction

    task automatic step(input logic [N-1:0] v, input logic [N-1:0] e,
                        input logic [N*LW-1:0] by);
        logic [N-1:0] normal, exp_acc, exp_ref, win_oh;
        bit           grant, open;
        int           widx;
        string        tag;
        @(negedge clk);
        req_valid = v; req_express = e; req_bytes = by;
        #2;
        normal = v & ~e;
        win_oh = '0; grant = 0; widx = 0;
        for (int p = 0; p < N; p++) begin
            bit elig;
            elig = normal[p] && (m_busy == 0) &&
                   (m_q.size() == 0 || (m_win && m_q[0] == p));
            if (elig && !grant) begin win_oh[p] = 1'b1; grant = 1; widx = p; end
        end
        exp_acc = (v & e) | win_oh;
        exp_ref = normal & ~win_oh;
        if ((v & e) != '0) tag = "R1";
        else if (m_busy != 0) tag = "R2";
        else if (m_q.size() != 0) tag = "R4";
        else tag = "R8";
        check(accept === exp_acc, tag, "accept", 32'(accept), 32'(exp_acc));
        check(refuse === exp_ref, "R3", "refuse", 32'(refuse), 32'(exp_ref));
        check(retry === m_retry, m_popped ? "R6" : "R5", "retry", 32'(retry), 32'(m_retry));
        check(((accept & refuse) == '0) && ($countones(accept & ~(v & e)) <= 1),
              "R10", "exclusive", 32'(accept & refuse), 32'h0);
        for (int p = 0; p < N; p++) if (retry[p]) begin retry_seen[p]++; retry_cyc[p] = cyc; end
        // advance the reference model to the next cycle
        open = (m_busy == 0) && (m_q.size() > 0) && !m_win;
        if (grant) begin
            if (m_win) begin void'(m_q.pop_front()); m_win = 0; m_popped = 1; end
            m_busy = occ(int'(by[widx*LW +: LW]));
        end else if (m_busy > 0) begin
            m_busy--;
        end
        for (int p = 0; p < N; p++) if (exp_ref[p] && !in_list(p)) m_q.push_back(p);
        m_retry = '0;
        if (open) begin m_win = 1; m_retry[m_q[0]] = 1'b1; end
        cyc++;
    endtask

    function automatic logic [N*LW-1:0] all_bytes(input logic [LW-1:0] b);
        logic [N*LW-1:0] r;
        for (int p = 0; p < N; p++) r[p*LW +: LW] = b;
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int a_cyc;
        void'($urandom(32'd2024));
        for (int p = 0; p < N; p++) begin retry_seen[p] = 0; retry_cyc[p] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #2;
        check(accept == '0 && refuse == '0 && retry == '0, "R9", "reset outputs",
              32'({accept, refuse, retry}), 32'h0);

        // Directed: ports 0,1,2 collide with 32-byte packets (two bus cycles)
        a_cyc = cyc;
        step(4'b0111, 4'b0000, all_bytes(8'd32));
        check(1'b1, "R9", "first request admitted", 32'h0, 32'h0);
        // port 2 asks again while busy: must not be listed twice
        step(4'b0100, 4'b0000, all_bytes(8'd32));
        for (int k = 0; k < 10; k++) step(m_retry, 4'b0000, all_bytes(8'd16));
        check(retry_seen[2] == 1, "R7", "port2 retry count", 32'(retry_seen[2]), 32'd1);
        check(retry_cyc[1] - a_cyc == 4, "R5", "head retry delay", 32'(retry_cyc[1] - a_cyc), 32'd4);
        check(retry_cyc[2] - retry_cyc[1] == 3, "R6", "next head delay",
              32'(retry_cyc[2] - retry_cyc[1]), 32'd3);

        // Directed: express snoop on every port while the bus is busy
        step(4'b0001, 4'b0000, all_bytes(8'd64));
        step(4'b1111, 4'b1111, all_bytes(8'd64));
        step(4'b1010, 4'b0010, all_bytes(8'd64));
        for (int k = 0; k < 12; k++) step(m_retry, 4'b0000, all_bytes(8'd0));

        // Constrained random mix
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0]    v, e;
            logic [N*LW-1:0] by;
            for (int p = 0; p < N; p++) begin
                v[p] = ($urandom % 100) < 30;
                e[p] = ($urandom % 100) < 15;
                if (m_retry[p] && ($urandom % 100) < 85) begin v[p] = 1'b1; e[p] = 1'b0; end
                by[p*LW +: LW] = LW'($urandom % 72);
            end
            step(v, e, by);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule